// File: doc/BRIEF.md
# Watchdog Register Front-End with Keyed Unlock

This block is the software-visible face of a two-stage watchdog. A single synchronous register bus (address, access size, write data, write strobe, read data) reaches three groups of state. A configuration register picks the clock scale, the interrupt kind raised at the end of the first stage, and whether the final expiry may reboot the system. A control register holds enable, free-run and a self-freezing lock bit. A 16-byte window carries the two stage preload values and a reload register used for keep-alive pings and for clearing the reboot-cause flag.

The preloads and the reload register are guarded. Before each guarded write, software writes two key values in turn to the reload offset. The first non-key write of half-word or word size that follows is the one that gets through, and the guard then closes again. The countdown core itself lives elsewhere. It consumes the registered control levels, the preloads and a one-cycle kick pulse. It returns the reboot-cause flag, which this block reports at two bit positions in a half-word read of the reload offset.

Offsets: the window is 0x00 to 0x0F (preload one at 0x0, preload two at 0x4, reload at 0xC). The configuration register is at 0x60 and the control register at 0x68. Access size encoding on `bus_size`: 0 byte, 1 half-word, 2 word, 3 ignored.

Top module: `wdt_regfront`

## Requirements
- R1: After reset: reboot enabled, slow clock scale, interrupt type 0, watchdog disabled, not free-running, unlocked, both preloads all ones (0xFFFFF), and no kick or clear pulse.
- R2: The guard opens when 0x80 and then 0x86 are written to offset 0xC, at any size. It passes exactly one protected write and then closes, so a second write without a new key pair has no effect.
- R3: While the guard is open, a word write to 0x0 loads preload one and a word write to 0x4 loads preload two, each with the low 20 bits of the data. The new value is visible the cycle after the write.
- R4: Writes to 0x0, 0x4 or 0xC are ignored while the guard is closed. Writing 0x86 without a preceding 0x80 does not open it.
- R5: While the guard is open, a half-word write to 0xC with bit 8 set raises `kick_o` for exactly one cycle, if the watchdog is enabled.
- R6: While the guard is open, a half-word write to 0xC with bit 9 or bit 12 set raises `clr_reboot_o` for exactly one cycle.
- R7: A half-word read of 0xC returns 0x1200 when `prev_reboot_i` is high and 0 otherwise. Byte or word reads of the window return 0.
- R8: A half-word write to 0x60 sets the configuration: bit 5 set disables reboot, bit 2 set selects the fast clock scale, and bits [1:0] give the interrupt type (the reserved value 1 is kept). A half-word read returns the same encoding with the other bits 0. Byte and word writes to 0x60 are ignored.
- R9: A byte write to 0x68 sets lock (bit 0), enable (bit 1) and free-run (bit 2), and a byte read returns them. Once lock is set, later writes to 0x68 change nothing until reset.
- R10: A transition of enable from 0 to 1 raises `kick_o` for one cycle. A ping while the watchdog is disabled gives no kick.
- R11: While the guard is open, a byte write that is not a key neither passes nor closes the guard. A half-word or word write to any window offset closes it, whether or not that write has an effect.
- R12: Writing 0x80 to 0xC at any time restarts the key sequence at its first step, even when the guard is already open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_rdata | output | DATA_W | Read data for the current address and size (combinational) |
| prev_reboot_i | input | 1 | Reboot-cause flag from the countdown core |
| reboot_en_o | output | 1 | Final expiry may reboot |
| fast_clk_o | output | 1 | Fast countdown clock scale selected |
| int_type_o | output | 2 | Interrupt kind for first-stage expiry |
| wdt_enable_o | output | 1 | Watchdog running |
| free_run_o | output | 1 | Restart at stage one after final expiry |
| locked_o | output | 1 | Control register frozen |
| preload1_o | output | PRELOAD_W | First-stage preload |
| preload2_o | output | PRELOAD_W | Second-stage preload |
| kick_o | output | 1 | One-cycle restart request to the core |
| clr_reboot_o | output | 1 | One-cycle request to clear the reboot-cause flag |

## Verification
On every cycle the assertions check the following. The lock bit freezes the control register. A rising enable always comes with a kick. Kicks never span two cycles. The preloads, configuration and clear pulse change only in the cycle after a matching write. The half-word reload read always mirrors the reboot-cause flag. Only the bench's scenarios can show the ordering behaviour of the key sequence: that exactly one write passes, that a non-key byte keeps the guard open, that a fresh 0x80 revokes an open guard, and that a lone 0x86 does nothing. The bench also sweeps every configuration code, every lock pattern and every ping/clear bit combination against values computed from the encodings.

// File: rtl/wdt_rf_pkg.sv
package wdt_rf_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        UL_IDLE  = 2'd0,
        UL_STEP1 = 2'd1,
        UL_OPEN  = 2'd2
    } unlock_st_e;

    localparam logic [7:0]  KEY_FIRST   = 8'h80;
    localparam logic [7:0]  KEY_SECOND  = 8'h86;
    localparam logic [15:0] CAUSE_RDVAL = 16'h1200;

    localparam int PING_BIT   = 8;
    localparam int CLR_BIT_LO = 9;
    localparam int CLR_BIT_HI = 12;

    localparam int CFG_NORBT_BIT = 5;
    localparam int CFG_FAST_BIT  = 2;

    localparam int CTL_LOCK_BIT = 0;
    localparam int CTL_EN_BIT   = 1;
    localparam int CTL_FREE_BIT = 2;

    typedef struct packed {
        unlock_st_e st;
    } unlock_regs_t;

    typedef struct packed {
        logic       reboot_en;
        logic       fast_clk;
        logic [1:0] int_type;
        logic       enable;
        logic       free_run;
        logic       locked;
    } ctrl_regs_t;

endpackage

// File: rtl/wdt_rf_unlock.sv
module wdt_rf_unlock
    import wdt_rf_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 32,
    parameter logic [ADDR_W-1:0] RELOAD_OFS = 'hC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              win_hit,
    input  logic [ADDR_W-1:0] addr,
    input  acc_size_e         size,
    input  logic [DATA_W-1:0] data_m,
    output logic              grant
);

    unlock_regs_t cur_q, nxt_d;
    logic         key1_hit, key2_hit, win_wr;

    assign win_wr   = wr_en && win_hit && (size != SZ_RSVD);
    assign key1_hit = (addr == RELOAD_OFS) && (data_m == DATA_W'(KEY_FIRST));
    assign key2_hit = (addr == RELOAD_OFS) && (data_m == DATA_W'(KEY_SECOND));

    always_comb begin
        nxt_d = cur_q;
        grant = 1'b0;
        if (win_wr) begin
            if (key1_hit) begin
                nxt_d.st = UL_STEP1;
            end else if (key2_hit && cur_q.st == UL_STEP1) begin
                nxt_d.st = UL_OPEN;
            end else if (cur_q.st == UL_OPEN && size != SZ_BYTE) begin
                nxt_d.st = UL_IDLE;
                grant    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.st <= UL_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

endmodule

// File: rtl/wdt_rf_ctrl.sv
module wdt_rf_ctrl
    import wdt_rf_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CFG_OFS  = 'h60,
    parameter logic [ADDR_W-1:0] LOCK_OFS = 'h68
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  acc_size_e         size,
    input  logic [3:0]        cfg_bits,   // {no_reboot, fast, type[1:0]}
    input  logic [2:0]        ctl_bits,   // {free, enable, lock}
    output ctrl_regs_t        regs,
    output logic              en_rise
);

    ctrl_regs_t cur_q, nxt_d;
    logic       cfg_wr, ctl_wr;

    assign cfg_wr = wr_en && (addr == CFG_OFS)  && (size == SZ_HALF);
    assign ctl_wr = wr_en && (addr == LOCK_OFS) && (size == SZ_BYTE) && !cur_q.locked;

    always_comb begin
        nxt_d   = cur_q;
        en_rise = 1'b0;
        if (cfg_wr) begin
            nxt_d.reboot_en = !cfg_bits[3];
            nxt_d.fast_clk  = cfg_bits[2];
            nxt_d.int_type  = cfg_bits[1:0];
        end
        if (ctl_wr) begin
            nxt_d.locked   = ctl_bits[CTL_LOCK_BIT];
            nxt_d.enable   = ctl_bits[CTL_EN_BIT];
            nxt_d.free_run = ctl_bits[CTL_FREE_BIT];
            en_rise        = ctl_bits[CTL_EN_BIT] && !cur_q.enable;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.reboot_en <= 1'b1;
            cur_q.fast_clk  <= 1'b0;
            cur_q.int_type  <= 2'd0;
            cur_q.enable    <= 1'b0;
            cur_q.free_run  <= 1'b0;
            cur_q.locked    <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign regs = cur_q;

endmodule

// File: rtl/wdt_rf_window.sv
module wdt_rf_window
    import wdt_rf_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                PRELOAD_W  = 20,
    parameter logic [ADDR_W-1:0] PRE1_OFS   = 'h0,
    parameter logic [ADDR_W-1:0] PRE2_OFS   = 'h4,
    parameter logic [ADDR_W-1:0] RELOAD_OFS = 'hC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 grant,
    input  logic [ADDR_W-1:0]    addr,
    input  acc_size_e            size,
    input  logic [PRELOAD_W-1:0] data_lo,
    input  logic                 enable,
    input  logic                 en_rise,
    output logic [PRELOAD_W-1:0] preload1,
    output logic [PRELOAD_W-1:0] preload2,
    output logic                 kick,
    output logic                 clr_cause
);

    typedef struct packed {
        logic [PRELOAD_W-1:0] p1;
        logic [PRELOAD_W-1:0] p2;
        logic                 kick;
        logic                 clr;
    } win_regs_t;

    win_regs_t cur_q, nxt_d;
    logic      reload_wr, ping_req;

    assign reload_wr = grant && (size == SZ_HALF) && (addr == RELOAD_OFS);
    assign ping_req  = reload_wr && data_lo[PING_BIT];

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.kick = (ping_req && enable) || en_rise;
        nxt_d.clr  = reload_wr && (data_lo[CLR_BIT_LO] || data_lo[CLR_BIT_HI]);
        if (grant && size == SZ_WORD) begin
            if (addr == PRE1_OFS) nxt_d.p1 = data_lo;
            if (addr == PRE2_OFS) nxt_d.p2 = data_lo;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.p1   <= '1;
            cur_q.p2   <= '1;
            cur_q.kick <= 1'b0;
            cur_q.clr  <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign preload1  = cur_q.p1;
    assign preload2  = cur_q.p2;
    assign kick      = cur_q.kick;
    assign clr_cause = cur_q.clr;

endmodule

// File: rtl/wdt_regfront.sv
module wdt_regfront
    import wdt_rf_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 32,
    parameter int                PRELOAD_W  = 20,
    parameter int                WIN_AW     = 4,
    parameter logic [ADDR_W-1:0] PRE1_OFS   = 'h0,
    parameter logic [ADDR_W-1:0] PRE2_OFS   = 'h4,
    parameter logic [ADDR_W-1:0] RELOAD_OFS = 'hC,
    parameter logic [ADDR_W-1:0] CFG_OFS    = 'h60,
    parameter logic [ADDR_W-1:0] LOCK_OFS   = 'h68
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [1:0]           bus_size,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic                 bus_wr,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 prev_reboot_i,
    output logic                 reboot_en_o,
    output logic                 fast_clk_o,
    output logic [1:0]           int_type_o,
    output logic                 wdt_enable_o,
    output logic                 free_run_o,
    output logic                 locked_o,
    output logic [PRELOAD_W-1:0] preload1_o,
    output logic [PRELOAD_W-1:0] preload2_o,
    output logic                 kick_o,
    output logic                 clr_reboot_o
);

    localparam int HALF_W = (DATA_W < 16) ? DATA_W : 16;

    acc_size_e         sz;
    logic              win_hit;
    logic [DATA_W-1:0] data_m;
    logic              grant;
    logic              en_rise;
    ctrl_regs_t        ctl;

    assign sz      = acc_size_e'(bus_size);
    assign win_hit = (bus_addr[ADDR_W-1:WIN_AW] == '0);

    // Bytes beyond the access size do not take part in key matching.
    always_comb begin
        data_m = '0;
        unique case (sz)
            SZ_BYTE: data_m[7:0]        = bus_wdata[7:0];
            SZ_HALF: data_m[HALF_W-1:0] = bus_wdata[HALF_W-1:0];
            default: data_m             = bus_wdata;
        endcase
    end

    wdt_rf_unlock #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .RELOAD_OFS (RELOAD_OFS)
    ) u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .win_hit (win_hit),
        .addr    (bus_addr),
        .size    (sz),
        .data_m  (data_m),
        .grant   (grant)
    );

    wdt_rf_ctrl #(
        .ADDR_W   (ADDR_W),
        .CFG_OFS  (CFG_OFS),
        .LOCK_OFS (LOCK_OFS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .size     (sz),
        .cfg_bits ({data_m[CFG_NORBT_BIT], data_m[CFG_FAST_BIT], data_m[1:0]}),
        .ctl_bits (data_m[2:0]),
        .regs     (ctl),
        .en_rise  (en_rise)
    );

    wdt_rf_window #(
        .ADDR_W     (ADDR_W),
        .PRELOAD_W  (PRELOAD_W),
        .PRE1_OFS   (PRE1_OFS),
        .PRE2_OFS   (PRE2_OFS),
        .RELOAD_OFS (RELOAD_OFS)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant     (grant),
        .addr      (bus_addr),
        .size      (sz),
        .data_lo   (data_m[PRELOAD_W-1:0]),
        .enable    (ctl.enable),
        .en_rise   (en_rise),
        .preload1  (preload1_o),
        .preload2  (preload2_o),
        .kick      (kick_o),
        .clr_cause (clr_reboot_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (win_hit) begin
            if (bus_addr == RELOAD_OFS && sz == SZ_HALF && prev_reboot_i) begin
                bus_rdata[HALF_W-1:0] = CAUSE_RDVAL[HALF_W-1:0];
            end
        end else if (bus_addr == CFG_OFS && sz == SZ_HALF) begin
            bus_rdata[CFG_NORBT_BIT] = !ctl.reboot_en;
            bus_rdata[CFG_FAST_BIT]  = ctl.fast_clk;
            bus_rdata[1:0]           = ctl.int_type;
        end else if (bus_addr == LOCK_OFS && sz == SZ_BYTE) begin
            bus_rdata[CTL_LOCK_BIT] = ctl.locked;
            bus_rdata[CTL_EN_BIT]   = ctl.enable;
            bus_rdata[CTL_FREE_BIT] = ctl.free_run;
        end
    end

    assign reboot_en_o  = ctl.reboot_en;
    assign fast_clk_o   = ctl.fast_clk;
    assign int_type_o   = ctl.int_type;
    assign wdt_enable_o = ctl.enable;
    assign free_run_o   = ctl.free_run;
    assign locked_o     = ctl.locked;

endmodule

// File: rtl/wdt_regfront_chk.sv
module wdt_regfront_chk #(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 32,
    parameter int                PRELOAD_W  = 20,
    parameter logic [ADDR_W-1:0] PRE1_OFS   = 'h0,
    parameter logic [ADDR_W-1:0] RELOAD_OFS = 'hC,
    parameter logic [ADDR_W-1:0] CFG_OFS    = 'h60
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [1:0]           bus_size,
    input logic                 bus_wr,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic                 prev_reboot_i,
    input logic                 reboot_en_o,
    input logic                 fast_clk_o,
    input logic [1:0]           int_type_o,
    input logic                 wdt_enable_o,
    input logic                 free_run_o,
    input logic                 locked_o,
    input logic [PRELOAD_W-1:0] preload1_o,
    input logic                 kick_o,
    input logic                 clr_reboot_o
);

    assert_lock_sticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> (locked_o && $stable(wdt_enable_o) && $stable(free_run_o)));

    assert_kick_on_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_enable_o) |-> kick_o);

    assert_kick_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        kick_o |=> !kick_o);

    assert_preload_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(preload1_o) |-> $past(bus_wr && bus_size == 2'd2 && bus_addr == PRE1_OFS));

    assert_cfg_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({reboot_en_o, fast_clk_o, int_type_o})
        |-> $past(bus_wr && bus_size == 2'd1 && bus_addr == CFG_OFS));

    assert_clr_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_reboot_o |-> $past(bus_wr && bus_size == 2'd1 && bus_addr == RELOAD_OFS));

    assert_cause_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == RELOAD_OFS && bus_size == 2'd1)
        |-> (bus_rdata == (prev_reboot_i ? DATA_W'(16'h1200) : '0)));

endmodule

bind wdt_regfront wdt_regfront_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PRELOAD_W  (PRELOAD_W),
    .PRE1_OFS   (PRE1_OFS),
    .RELOAD_OFS (RELOAD_OFS),
    .CFG_OFS    (CFG_OFS)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_size      (bus_size),
    .bus_wr        (bus_wr),
    .bus_rdata     (bus_rdata),
    .prev_reboot_i (prev_reboot_i),
    .reboot_en_o   (reboot_en_o),
    .fast_clk_o    (fast_clk_o),
    .int_type_o    (int_type_o),
    .wdt_enable_o  (wdt_enable_o),
    .free_run_o    (free_run_o),
    .locked_o      (locked_o),
    .preload1_o    (preload1_o),
    .kick_o        (kick_o),
    .clr_reboot_o  (clr_reboot_o)
);

// File: tb/test_wdt_regfront.sv
module test_wdt_regfront;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 100000;
    localparam logic [1:0] B = 2'd0, H = 2'd1, W = 2'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_rdata;
    logic        prev_reboot_i = 1'b0;
    logic        reboot_en_o, fast_clk_o, wdt_enable_o, free_run_o, locked_o;
    logic [1:0]  int_type_o;
    logic [19:0] preload1_o, preload2_o;
    logic        kick_o, clr_reboot_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_regfront i_wdt_regfront (
        .clk (clk), .rst_n (rst_n),
        .bus_addr (bus_addr), .bus_size (bus_size), .bus_wdata (bus_wdata),
        .bus_wr (bus_wr), .bus_rdata (bus_rdata), .prev_reboot_i (prev_reboot_i),
        .reboot_en_o (reboot_en_o), .fast_clk_o (fast_clk_o), .int_type_o (int_type_o),
        .wdt_enable_o (wdt_enable_o), .free_run_o (free_run_o), .locked_o (locked_o),
        .preload1_o (preload1_o), .preload2_o (preload2_o),
        .kick_o (kick_o), .clr_reboot_o (clr_reboot_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = s; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = s; bus_wr = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic open_guard();
        wr(8'h0C, H, 32'h80);
        wr(8'h0C, H, 32'h86);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= WDOG_LIMIT) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WDOG_LIMIT);
            finish_run();
        end
    end

    initial begin
        logic [31:0] r, v, pv;
        logic [19:0] exp_p1;

        do_reset();

        // R1 reset state
        chk("R1", "reboot_en", 32'(reboot_en_o), 32'd1);
        chk("R1", "fast_clk", 32'(fast_clk_o), 32'd0);
        chk("R1", "int_type", 32'(int_type_o), 32'd0);
        chk("R1", "ctl bits", {29'd0, free_run_o, wdt_enable_o, locked_o}, 32'd0);
        chk("R1", "preload1", 32'(preload1_o), 32'hFFFFF);
        chk("R1", "preload2", 32'(preload2_o), 32'hFFFFF);
        chk("R1", "pulses", {30'd0, kick_o, clr_reboot_o}, 32'd0);

        // R8 sweep of every configuration code
        for (int c = 0; c < 64; c++) begin
            wr(8'h60, H, 32'(c));
            chk("R8", "reboot_en", 32'(reboot_en_o), 32'(((c >> 5) & 1) == 0));
            chk("R8", "fast_clk", 32'(fast_clk_o), 32'((c >> 2) & 1));
            chk("R8", "int_type", 32'(int_type_o), 32'(c & 3));
            rd(8'h60, H, r);
            chk("R8", "readback", r, 32'(c & 32'h27));
        end
        wr(8'h60, H, 32'h0);
        wr(8'h60, B, 32'h27);
        rd(8'h60, H, r);
        chk("R8", "byte write ignored", r, 32'h0);
        wr(8'h60, W, 32'h27);
        rd(8'h60, H, r);
        chk("R8", "word write ignored", r, 32'h0);

        // R3 preload sweep
        for (int i = 0; i < 8; i++) begin
            v = 32'(i) * 32'h1234_5679 + 32'h0F0F_0000;
            open_guard();
            wr(8'h00, W, v);
            chk("R3", "preload1", 32'(preload1_o), v & 32'hFFFFF);
            open_guard();
            wr(8'h04, W, ~v);
            chk("R3", "preload2", 32'(preload2_o), ~v & 32'hFFFFF);
        end
        exp_p1 = preload1_o;

        // R4 writes without the key pair
        wr(8'h00, W, 32'h12345);
        chk("R4", "closed write", 32'(preload1_o), 32'(exp_p1));
        wr(8'h0C, H, 32'h86);
        wr(8'h00, W, 32'h23456);
        chk("R4", "lone second key", 32'(preload1_o), 32'(exp_p1));

        // R2 one write per key pair, byte-size keys
        wr(8'h0C, B, 32'h80);
        wr(8'h0C, B, 32'h86);
        wr(8'h00, W, 32'hAAAAA);
        chk("R2", "first write passes", 32'(preload1_o), 32'hAAAAA);
        wr(8'h00, W, 32'h55555);
        chk("R2", "second write blocked", 32'(preload1_o), 32'hAAAAA);

        // R12 restart of the key sequence
        wr(8'h0C, H, 32'h80);
        wr(8'h0C, H, 32'h80);
        wr(8'h0C, H, 32'h86);
        wr(8'h00, W, 32'h13579);
        chk("R12", "repeated first key", 32'(preload1_o), 32'h13579);
        open_guard();
        wr(8'h0C, W, 32'h80);
        wr(8'h00, W, 32'h24680);
        chk("R12", "first key revokes open guard", 32'(preload1_o), 32'h13579);

        // R11 byte writes keep the guard open, half-words consume it
        open_guard();
        wr(8'h0C, B, 32'h55);
        wr(8'h00, W, 32'h0BEEF);
        chk("R11", "non-key byte keeps guard", 32'(preload1_o), 32'h0BEEF);
        open_guard();
        wr(8'h08, H, 32'h1234);
        wr(8'h00, W, 32'h0CAFE);
        chk("R11", "half-word at 0x8 consumes guard", 32'(preload1_o), 32'h0BEEF);

        // R10 enable rising gives a kick
        wr(8'h68, B, 32'h2);
        chk("R10", "enable", 32'(wdt_enable_o), 32'd1);
        chk("R10", "kick on enable", 32'(kick_o), 32'd1);
        @(negedge clk);
        chk("R10", "kick one cycle", 32'(kick_o), 32'd0);

        // R5 / R6 sweep of ping and clear bits
        for (int m = 0; m < 8; m++) begin
            pv = ((m & 1) != 0 ? 32'h100 : 32'h0) | ((m & 2) != 0 ? 32'h200 : 32'h0)
               | ((m & 4) != 0 ? 32'h1000 : 32'h0);
            open_guard();
            wr(8'h0C, H, pv);
            chk("R5", "kick", 32'(kick_o), 32'(m & 1));
            chk("R6", "clear", 32'(clr_reboot_o), 32'((m & 6) != 0));
            @(negedge clk);
            chk("R6", "pulses drop", {30'd0, kick_o, clr_reboot_o}, 32'd0);
        end
        wr(8'h0C, H, 32'h300);
        chk("R4", "ping without keys", {30'd0, kick_o, clr_reboot_o}, 32'd0);

        // R10 ping while disabled
        wr(8'h68, B, 32'h0);
        chk("R10", "disabled", 32'(wdt_enable_o), 32'd0);
        chk("R10", "no kick on disable", 32'(kick_o), 32'd0);
        open_guard();
        wr(8'h0C, H, 32'h100);
        chk("R10", "ping while disabled", 32'(kick_o), 32'd0);

        // R7 reads
        prev_reboot_i = 1'b1;
        rd(8'h0C, H, r); chk("R7", "half read flag set", r, 32'h1200);
        rd(8'h0C, W, r); chk("R7", "word read", r, 32'h0);
        rd(8'h0C, B, r); chk("R7", "byte read", r, 32'h0);
        rd(8'h00, H, r); chk("R7", "other offset", r, 32'h0);
        prev_reboot_i = 1'b0;
        rd(8'h0C, H, r); chk("R7", "half read flag clear", r, 32'h0);

        // R9 lock sweep
        for (int k = 0; k < 8; k++) begin
            do_reset();
            wr(8'h68, B, 32'(k));
            chk("R9", "lock", 32'(locked_o), 32'(k & 1));
            chk("R9", "enable", 32'(wdt_enable_o), 32'((k >> 1) & 1));
            chk("R9", "free_run", 32'(free_run_o), 32'((k >> 2) & 1));
            rd(8'h68, B, r);
            chk("R9", "readback", r, 32'(k));
            wr(8'h68, B, 32'(~k & 7));
            rd(8'h68, B, r);
            chk("R9", "second write", r, ((k & 1) != 0) ? 32'(k) : 32'(~k & 7));
        end

        finish_run();
    end

endmodule